// File: doc/BRIEF.md
# Preset Multi-Rail Power Sequencer

This block drives the enable lines of four display bias rails: a positive source rail, a negative source rail, a positive gate rail and a negative gate rail. A 3-bit mode input picks one of seven fixed orderings. When the filtered enable input rises, the block waits for the main boost converter to report that its soft-start is done. It then switches the rails on one at a time, in fixed slots one `SLOT_MS` milliseconds apart.

When the filtered enable falls, the block switches the rails off in the mode's shutdown order. These slots are timed from the enable edge. If the enable falls while power-up is still running, power-up stops and shutdown starts at once. Slots that belong to rails that never came on pass without effect.

Each enabled rail is watched for a short report and for a power-good level that stays low too long. Either condition drops every rail in the same cycle and latches a fault flag. The backlight enable is raised only once the full power-up has finished and every rail that the mode uses reports power good.

Top module: `bias_seq_top`

## Requirements
- R1: After reset `rail_en`, `bl_en` and `fault` are all 0. Rail index mapping: bit 0 = positive source (POS), bit 1 = negative source (NEG), bit 2 = positive gate (GVDD), bit 3 = negative gate (GVEE).
- R2: A level change on `en_pin` that lasts fewer than `FILT_CYC` clock cycles has no effect on the rails, whether the rails are off or fully on.
- R3: After a filtered enable rise, no rail is switched on while `ss_done` is low. The first power-up slot falls `SLOT_MS` ms after `ss_done` is first seen high.
- R4: Power-up switches on one rail per slot. Slot k (k = 0..3) falls (k+1)*`SLOT_MS` ms after `ss_done`. The order by mode, as rail indices:
  - mode 0 and mode 7: 0,1,3,2
  - mode 1: 0,1,2,3
  - mode 2: 1,0,3,2
  - mode 3: 0,3,2
  - mode 4: 0,2,3
  - mode 5: 0,1,2,3
  - mode 6: 3,2,1,0
- R5: In modes 3 and 4 the NEG rail (bit 1) is never enabled.
- R6: Shutdown switches off one rail per slot. Slot k falls (k+1)*`SLOT_MS` ms after the filtered enable falls. The order by mode:
  - mode 0 and mode 7: 2,3,1,0
  - mode 1: 3,2,1,0
  - mode 2: 2,3,0,1
  - mode 3: 2,3,0
  - mode 4: 3,2,0
  - mode 5: 2,3,0,1
  - mode 6: 0,1,2,3
- R7: If the filtered enable falls during power-up, no further rail is switched on, and the rails that are on go off in their shutdown slots.
- R8: A short report on an enabled rail clears all of `rail_en` and sets `fault` within two cycles. A short report on a disabled rail has no effect.
- R9: An enabled rail whose power-good input stays low for `FAULT_MS` ms trips the fault. A low lasting clearly less than that (3 ms of 5 ms here) does not trip it.
- R10: `fault` stays set with all rails off while the filtered enable is high. It clears once the filtered enable is low, and the rails stay off until a new enable rise.
- R11: `bl_en` is high only when power-up has completed and every rail the mode uses has its power-good input high. The NEG rail is ignored in modes 3 and 4.
- R12: Outside a fault shut-off, at most one bit of `rail_en` changes per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_HZ` Hz |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Raw enable request, asynchronous to clk |
| mode | input | 3 | Ordering preset, captured at each enable rise |
| ss_done | input | 1 | Main boost soft-start complete |
| pgood | input | 4 | Per-rail power-good, rail index as in R1 |
| short_det | input | 4 | Per-rail short report, rail index as in R1 |
| rail_en | output | 4 | Per-rail enable, rail index as in R1 |
| bl_en | output | 1 | Backlight enable |
| fault | output | 1 | Latched fault flag |

## Verification
The bench builds the block with `CLK_HZ` = 4000, `SLOT_MS` = 3, `FAULT_MS` = 5 and `FILT_CYC` = 8. With these values a millisecond is four cycles and a full power-up or shutdown takes about fifty cycles. That makes it cheap to sweep all eight mode codes through a complete up and down cycle, checking the rail set at the middle of every slot. The short fault window also lets a power-good drop be held both clearly below and clearly above the trip time, and the short enable filter lets glitches be checked just under the filter length.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

  localparam int NRAIL = 4;

  localparam logic [1:0] RAIL_POS  = 2'd0;
  localparam logic [1:0] RAIL_NEG  = 2'd1;
  localparam logic [1:0] RAIL_GVDD = 2'd2;
  localparam logic [1:0] RAIL_GVEE = 2'd3;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_SS,
    ST_UP,
    ST_ON,
    ST_DOWN,
    ST_FAULT
  } seq_state_e;

  typedef struct packed {
    logic [3:0][1:0] slot;  // slot[k] = rail switched in step k
    logic [2:0]      cnt;   // number of steps used
  } rail_order_t;

  function automatic rail_order_t mk_order(input logic [1:0] a, input logic [1:0] b,
                                           input logic [1:0] c, input logic [1:0] d,
                                           input logic [2:0] n);
    rail_order_t o;
    o.slot[0] = a;
    o.slot[1] = b;
    o.slot[2] = c;
    o.slot[3] = d;
    o.cnt     = n;
    return o;
  endfunction

  function automatic rail_order_t up_order(input logic [2:0] m);
    case (m)
      3'd1:    return mk_order(RAIL_POS,  RAIL_NEG,  RAIL_GVDD, RAIL_GVEE, 3'd4);
      3'd2:    return mk_order(RAIL_NEG,  RAIL_POS,  RAIL_GVEE, RAIL_GVDD, 3'd4);
      3'd3:    return mk_order(RAIL_POS,  RAIL_GVEE, RAIL_GVDD, RAIL_POS,  3'd3);
      3'd4:    return mk_order(RAIL_POS,  RAIL_GVDD, RAIL_GVEE, RAIL_POS,  3'd3);
      3'd5:    return mk_order(RAIL_POS,  RAIL_NEG,  RAIL_GVDD, RAIL_GVEE, 3'd4);
      3'd6:    return mk_order(RAIL_GVEE, RAIL_GVDD, RAIL_NEG,  RAIL_POS,  3'd4);
      default: return mk_order(RAIL_POS,  RAIL_NEG,  RAIL_GVEE, RAIL_GVDD, 3'd4);
    endcase
  endfunction

  function automatic rail_order_t down_order(input logic [2:0] m);
    case (m)
      3'd1:    return mk_order(RAIL_GVEE, RAIL_GVDD, RAIL_NEG,  RAIL_POS,  3'd4);
      3'd2:    return mk_order(RAIL_GVDD, RAIL_GVEE, RAIL_POS,  RAIL_NEG,  3'd4);
      3'd3:    return mk_order(RAIL_GVDD, RAIL_GVEE, RAIL_POS,  RAIL_POS,  3'd3);
      3'd4:    return mk_order(RAIL_GVEE, RAIL_GVDD, RAIL_POS,  RAIL_POS,  3'd3);
      3'd5:    return mk_order(RAIL_GVDD, RAIL_GVEE, RAIL_POS,  RAIL_NEG,  3'd4);
      3'd6:    return mk_order(RAIL_POS,  RAIL_NEG,  RAIL_GVDD, RAIL_GVEE, 3'd4);
      default: return mk_order(RAIL_GVDD, RAIL_GVEE, RAIL_NEG,  RAIL_POS,  3'd4);
    endcase
  endfunction

  function automatic logic [NRAIL-1:0] used_mask(input logic [2:0] m);
    if (m == 3'd3 || m == 3'd4) return 4'b1101;
    return 4'b1111;
  endfunction

endpackage

// File: rtl/bias_seq_deglitch.sv
module bias_seq_deglitch #(
  parameter int FILT_CYC = 350
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

  logic [1:0]    sync_q;
  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (sync_q[1] == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_d = sync_q[1];
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/bias_seq_timebase.sv
module bias_seq_timebase #(
  parameter int CYC_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_MS - 1);

  logic [PW-1:0] pre_q, pre_d;

  assign tick = (pre_q == PRE_LAST) && !clr;

  always_comb begin
    if (clr || pre_q == PRE_LAST) pre_d = '0;
    else                          pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/bias_seq_faultmon.sv
module bias_seq_faultmon #(
  parameter int NR       = 4,
  parameter int FAULT_MS = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [NR-1:0] rail_en,
  input  logic [NR-1:0] pgood,
  input  logic [NR-1:0] short_det,
  output logic          trip
);
  localparam int FW = $clog2(FAULT_MS + 1);
  localparam logic [FW-1:0] UV_LIMIT = FW'(FAULT_MS);

  logic [NR-1:0] uv_hit;

  for (genvar i = 0; i < NR; i++) begin : g_rail
    logic [FW-1:0] low_q, low_d;

    always_comb begin
      low_d = low_q;
      if (!(rail_en[i] && !pgood[i]))         low_d = '0;
      else if (tick && low_q != UV_LIMIT)     low_d = low_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) low_q <= '0;
      else        low_q <= low_d;
    end

    assign uv_hit[i] = (low_q == UV_LIMIT);
  end

  assign trip = (|(short_det & rail_en)) || (|uv_hit);
endmodule

// File: rtl/bias_seq_top.sv
module bias_seq_top
  import bias_seq_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int SLOT_MS  = 15,
  parameter int FAULT_MS = 50,
  parameter int FILT_CYC = 350
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_pin,
  input  logic [2:0]       mode,
  input  logic             ss_done,
  input  logic [NRAIL-1:0] pgood,
  input  logic [NRAIL-1:0] short_det,
  output logic [NRAIL-1:0] rail_en,
  output logic             bl_en,
  output logic             fault
);
  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int MSW        = (SLOT_MS > 1) ? $clog2(SLOT_MS) : 1;
  localparam logic [MSW-1:0] MS_LAST = MSW'(SLOT_MS - 1);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic en_f;
  logic tick;
  logic tb_clr;
  logic trip;

  bias_seq_deglitch #(.FILT_CYC(FILT_CYC)) i_deglitch (
    .clk  (clk),
    .rst_n(rst_i_n),
    .raw  (en_pin),
    .filt (en_f)
  );

  bias_seq_timebase #(.CYC_PER_MS(CYC_PER_MS)) i_timebase (
    .clk  (clk),
    .rst_n(rst_i_n),
    .clr  (tb_clr),
    .tick (tick)
  );

  seq_state_e       state_q, state_d;
  logic [1:0]       step_q, step_d;
  logic [MSW-1:0]   ms_q, ms_d;
  logic [2:0]       mode_q, mode_d;
  logic [NRAIL-1:0] rail_q, rail_d;
  logic             fault_q, fault_d;
  logic             bl_q, bl_d;
  rail_order_t      up_ord, dn_ord;
  logic             up_last, dn_last;

  bias_seq_faultmon #(.NR(NRAIL), .FAULT_MS(FAULT_MS)) i_faultmon (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .tick     (tick),
    .rail_en  (rail_q),
    .pgood    (pgood),
    .short_det(short_det),
    .trip     (trip)
  );

  assign up_ord  = up_order(mode_q);
  assign dn_ord  = down_order(mode_q);
  assign up_last = ({1'b0, step_q} == up_ord.cnt - 3'd1);
  assign dn_last = ({1'b0, step_q} == dn_ord.cnt - 3'd1);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    ms_d    = ms_q;
    mode_d  = mode_q;
    rail_d  = rail_q;
    fault_d = fault_q;
    tb_clr  = 1'b0;

    case (state_q)
      ST_OFF: begin
        if (en_f) begin
          state_d = ST_WAIT_SS;
          mode_d  = mode;
        end
      end
      ST_WAIT_SS: begin
        if (!en_f) begin
          state_d = ST_OFF;
        end else if (ss_done) begin
          state_d = ST_UP;
          step_d  = '0;
          ms_d    = '0;
          tb_clr  = 1'b1;
        end
      end
      ST_UP: begin
        if (!en_f) begin
          state_d = ST_DOWN;
          step_d  = '0;
          ms_d    = '0;
          tb_clr  = 1'b1;
        end else if (tick) begin
          if (ms_q == MS_LAST) begin
            ms_d                       = '0;
            rail_d[up_ord.slot[step_q]] = 1'b1;
            if (up_last) state_d = ST_ON;
            else         step_d  = step_q + 1'b1;
          end else begin
            ms_d = ms_q + 1'b1;
          end
        end
      end
      ST_ON: begin
        if (!en_f) begin
          state_d = ST_DOWN;
          step_d  = '0;
          ms_d    = '0;
          tb_clr  = 1'b1;
        end
      end
      ST_DOWN: begin
        if (tick) begin
          if (ms_q == MS_LAST) begin
            ms_d                       = '0;
            rail_d[dn_ord.slot[step_q]] = 1'b0;
            if (dn_last) state_d = ST_OFF;
            else         step_d  = step_q + 1'b1;
          end else begin
            ms_d = ms_q + 1'b1;
          end
        end
      end
      ST_FAULT: begin
        rail_d = '0;
        if (!en_f) begin
          state_d = ST_OFF;
          fault_d = 1'b0;
        end
      end
      default: state_d = ST_OFF;
    endcase

    if (trip && state_q != ST_FAULT) begin
      state_d = ST_FAULT;
      rail_d  = '0;
      fault_d = 1'b1;
    end

    bl_d = (state_d == ST_ON) && (&(pgood | ~used_mask(mode_q)));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_OFF;
      step_q  <= '0;
      ms_q    <= '0;
      mode_q  <= '0;
      rail_q  <= '0;
      fault_q <= 1'b0;
      bl_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      ms_q    <= ms_d;
      mode_q  <= mode_d;
      rail_q  <= rail_d;
      fault_q <= fault_d;
      bl_q    <= bl_d;
    end
  end

  assign rail_en = rail_q;
  assign bl_en   = bl_q;
  assign fault   = fault_q;
endmodule

// File: rtl/bias_seq_chk.sv
module bias_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rail_en,
  input logic       bl_en,
  input logic       fault,
  input logic       en_filt,
  input logic [2:0] mode_q
);
  AST_FAULT_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (rail_en == 4'b0000)); // R8

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && en_filt) |=> fault); // R10

  AST_BL_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    bl_en |-> (!fault && rail_en[0])); // R11

  AST_NEG_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd3 || mode_q == 3'd4) |-> !rail_en[1]); // R5

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fault || $countones(rail_en ^ $past(rail_en)) <= 1)); // R12
endmodule

bind bias_seq_top bias_seq_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rail_en(rail_en),
  .bl_en  (bl_en),
  .fault  (fault),
  .en_filt(en_f),
  .mode_q (mode_q)
);

// File: tb/test_bias_seq_top.sv
module test_bias_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_CLK_HZ   = 4000;
  localparam int T_SLOT_MS  = 3;
  localparam int T_FAULT_MS = 5;
  localparam int T_FILT     = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_pin;
  logic [2:0] mode;
  logic       ss_done;
  logic [3:0] pg_block;
  logic [3:0] pgood;
  logic [3:0] short_det;
  logic [3:0] rail_en;
  logic       bl_en;
  logic       fault;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pgood = rail_en & ~pg_block;

  bias_seq_top #(
    .CLK_HZ(T_CLK_HZ), .SLOT_MS(T_SLOT_MS), .FAULT_MS(T_FAULT_MS), .FILT_CYC(T_FILT)
  ) i_bias_seq_top (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .mode(mode), .ss_done(ss_done),
    .pgood(pgood), .short_det(short_det), .rail_en(rail_en), .bl_en(bl_en), .fault(fault)
  );

  // Orders written as four decimal digits, first step leftmost.
  function automatic int up_code(int m);
    case (m)
      1: return 123;   2: return 1032; 3: return 320; 4: return 230;
      5: return 123;   6: return 3210; default: return 132;
    endcase
  endfunction

  function automatic int dn_code(int m);
    case (m)
      1: return 3210;  2: return 2301; 3: return 2300; 4: return 3200;
      5: return 2301;  6: return 123;  default: return 2310;
    endcase
  endfunction

  function automatic int n_steps(int m);
    return (m == 3 || m == 4) ? 3 : 4;
  endfunction

  function automatic int digit(int code, int k);
    int p = 1;
    for (int j = 0; j < 3 - k; j++) p = p * 10;
    return (code / p) % 10;
  endfunction

  function automatic logic [3:0] up_set(int m, int k);
    logic [3:0] s = 4'b0000;
    for (int j = 0; j <= k && j < n_steps(m); j++) s[digit(up_code(m), j)] = 1'b1;
    return s;
  endfunction

  function automatic logic [3:0] dn_set(int m, logic [3:0] start, int k);
    logic [3:0] s = start;
    for (int j = 0; j <= k && j < n_steps(m); j++) s[digit(dn_code(m), j)] = 1'b0;
    return s;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; en_pin = 1'b0; mode = 3'd0; ss_done = 1'b0;
    pg_block = 4'b0000; short_det = 4'b0000;
    cyc(4);
    rst_n = 1'b1;
    cyc(6);
    chk("R1 reset rails", rail_en, 4'b0000);
    chk("R1 reset bl_en", {3'b0, bl_en}, 4'b0000);
    chk("R1 reset fault", {3'b0, fault}, 4'b0000);

    // R4 / R6 / R11 sweep over every mode code
    for (int m = 0; m < 8; m++) begin
      logic [3:0] full;
      mode = 3'(m); ss_done = 1'b1; en_pin = 1'b1;
      cyc(30);
      chk($sformatf("R4 mode%0d slot0", m), rail_en, up_set(m, 0));
      for (int k = 1; k < 4; k++) begin
        cyc(12);
        chk($sformatf("R4 mode%0d slot%0d", m, k), rail_en, up_set(m, k));
      end
      full = up_set(m, 3);
      if (m == 3 || m == 4) chk($sformatf("R5 mode%0d neg off", m), {3'b0, rail_en[1]}, 4'b0000);
      cyc(4);
      chk($sformatf("R11 mode%0d bl on", m), {3'b0, bl_en}, 4'b0001);
      cyc(10);
      en_pin = 1'b0;
      cyc(29);
      chk($sformatf("R6 mode%0d slot0", m), rail_en, dn_set(m, full, 0));
      for (int k = 1; k < 4; k++) begin
        cyc(12);
        chk($sformatf("R6 mode%0d slot%0d", m, k), rail_en, dn_set(m, full, k));
      end
      cyc(15);
      chk($sformatf("R6 mode%0d all off", m), rail_en, 4'b0000);
    end

    // R2: short glitch while off
    mode = 3'd1; en_pin = 1'b1;
    cyc(5);
    en_pin = 1'b0;
    cyc(60);
    chk("R2 glitch while off", rail_en, 4'b0000);

    // R3: hold ss_done low
    ss_done = 1'b0; en_pin = 1'b1;
    cyc(100);
    chk("R3 no rail before ss_done", rail_en, 4'b0000);
    ss_done = 1'b1;
    cyc(7);
    chk("R3 slot not yet", rail_en, 4'b0000);
    cyc(12);
    chk("R3 first slot after ss_done", rail_en, 4'b0001);
    cyc(50);
    chk("R4 mode1 full", rail_en, 4'b1111);

    // R2: low glitch while on
    en_pin = 1'b0;
    cyc(5);
    en_pin = 1'b1;
    cyc(40);
    chk("R2 glitch while on", rail_en, 4'b1111);

    // R11: power-good drop on a used rail lowers bl_en
    pg_block = 4'b0100;
    cyc(4);
    chk("R11 bl off on pgood drop", {3'b0, bl_en}, 4'b0000);
    // R9: 3 ms low does not trip
    cyc(8);
    chk("R9 short low no fault", {3'b0, fault}, 4'b0000);
    pg_block = 4'b0000;
    cyc(4);
    chk("R9 rails kept", rail_en, 4'b1111);
    chk("R11 bl back on", {3'b0, bl_en}, 4'b0001);
    pg_block = 4'b0100;
    cyc(28);
    chk("R9 long low trips", {3'b0, fault}, 4'b0001);
    chk("R9 rails dropped", rail_en, 4'b0000);
    pg_block = 4'b0000;
    cyc(40);
    chk("R10 fault held", {3'b0, fault}, 4'b0001);
    chk("R10 rails stay off", rail_en, 4'b0000);
    en_pin = 1'b0;
    cyc(20);
    chk("R10 fault cleared", {3'b0, fault}, 4'b0000);
    cyc(60);
    chk("R10 no restart", rail_en, 4'b0000);

    // R8: short on disabled then enabled rail, mode 3
    mode = 3'd3; en_pin = 1'b1;
    cyc(75);
    chk("R4 mode3 full", rail_en, 4'b1101);
    chk("R11 mode3 bl ignores neg", {3'b0, bl_en}, 4'b0001);
    short_det = 4'b0010;
    cyc(2);
    short_det = 4'b0000;
    cyc(2);
    chk("R8 short on off rail ignored", {3'b0, fault}, 4'b0000);
    chk("R8 rails unchanged", rail_en, 4'b1101);
    short_det = 4'b0100;
    cyc(1);
    short_det = 4'b0000;
    cyc(1);
    chk("R8 short trips", {3'b0, fault}, 4'b0001);
    chk("R8 all rails off", rail_en, 4'b0000);
    en_pin = 1'b0;
    cyc(20);
    chk("R10 clear after short", {3'b0, fault}, 4'b0000);

    // R7: abort during power-up, mode 0
    mode = 3'd0; en_pin = 1'b1;
    cyc(44);
    en_pin = 1'b0;
    cyc(29);
    chk("R7 abort slot0", rail_en, 4'b1011);
    cyc(12);
    chk("R7 abort slot1", rail_en, 4'b0011);
    cyc(12);
    chk("R7 abort slot2", rail_en, 4'b0001);
    cyc(12);
    chk("R7 abort slot3", rail_en, 4'b0000);
    cyc(20);
    chk("R7 stays off", rail_en, 4'b0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule